// File: doc/BRIEF.md
# Serial Clock Divider with Fallback Interval Timer

This block divides the system clock down to a serial shift clock for a synchronous serial master. It uses a 16-bit down-counter that reloads from a value assembled from two 8-bit bytes. Each time the counter expires, it emits a one-cycle tick. In serial mode every tick flips the shift clock, so one full clock period lasts two reload intervals. The resulting bit rate is the system clock frequency divided by twice the reload value. A reload value of zero stands for 65536, which gives the slowest divisor, 131072.

When the serial function is switched off, the same counter keeps running as a general 16-bit interval timer, provided its interrupt enable is set. Each timer expiry then drives a one-cycle interrupt pulse. That pulse goes only to the interrupt request output and touches no serial status. When neither function is enabled, the counter is parked at the current reload value. A new reload value is picked up only when the counter reloads, never part-way through a count.

Top module: `spi_baud_timer`

## Requirements
- R1: The reload value is {`rate_hi`,`rate_lo`} (high byte in bits 15:8). While running, the counter steps down by one each cycle. The cycle in which it stands at 1 asserts `baud_tick` and reloads it, so with reload N>0 the ticks are exactly N cycles apart.
- R2: A reload value of 0000h counts as 65536, so the ticks are 65536 cycles apart.
- R3: The internal count always lies in 1..65536.
- R4: While `ser_en`=1, `sck` inverts in the cycle after each `baud_tick`, which gives an `sck` period of 2N cycles. While `ser_en`=0, `sck` is 0 from the next cycle on.
- R5: With `ser_en`=0 and `tmr_irq_en`=1, `tmr_irq` is high in exactly the cycles in which `baud_tick` is high.
- R6: With `ser_en`=1, `tmr_irq` stays 0 whatever the value of `tmr_irq_en`.
- R7: A change of the reload bytes in the middle of a count leaves the current interval unchanged. The new value sets the length of the interval that starts at the next reload.
- R8: With `ser_en`=0 and `tmr_irq_en`=0, no tick occurs and the counter tracks the current reload value. After either enable is raised, the first tick comes exactly N cycles later.
- R9: While `rst_n` is low and after its release, `baud_tick`, `sck` and `tmr_irq` are 0. The count resets to 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_hi | input | 8 | Reload value, high byte |
| rate_lo | input | 8 | Reload value, low byte |
| ser_en | input | 1 | Serial clock generation enable |
| tmr_irq_en | input | 1 | Timer interrupt enable (effective while ser_en=0) |
| baud_tick | output | 1 | One-cycle pulse on counter expiry (shift clock toggle enable) |
| sck | output | 1 | Serial clock level |
| tmr_irq | output | 1 | One-cycle timer interrupt request |

## Verification
`baud_tick` and `tmr_irq` are combinational from the registered count. They are therefore due in the same cycle in which the count stands at 1, which is N cycles after the enable edge or after the previous tick. `sck` is registered, so its new level appears one cycle after the tick. The bench drives inputs just after a rising edge and samples at the falling edge. Its behavioural model is updated on the rising edge with the inputs that held before that edge, so every compared value belongs to the same cycle as the design's. Directed interval measurements count falling edges from the stimulus cycle up to and including the tick cycle.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned RATE_W = 2 * BYTE_W;
  localparam int unsigned CNT_W  = RATE_W + 1;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/spi_baud_reload.sv
module spi_baud_reload #(
  parameter int unsigned BYTE_W = spi_baud_pkg::BYTE_W,
  localparam int unsigned RW = 2 * BYTE_W,
  localparam int unsigned CW = RW + 1
) (
  input  logic [BYTE_W-1:0] hi_byte,
  input  logic [BYTE_W-1:0] lo_byte,
  output logic [CW-1:0]     reload
);
  // Zero in the raw field stands for the full 2^RW span.
  function automatic logic [CW-1:0] effective(input logic [RW-1:0] raw);
    logic [CW-1:0] r;
    if (raw == '0) r = {1'b1, {RW{1'b0}}};
    else           r = {1'b0, raw};
    return r;
  endfunction

  logic [RW-1:0] raw_w;
  assign raw_w  = {hi_byte, lo_byte};
  assign reload = effective(raw_w);
endmodule

// File: rtl/spi_baud_counter.sv
module spi_baud_counter #(
  parameter int unsigned CW = spi_baud_pkg::CNT_W,
  localparam logic [CW-1:0] FULL = {1'b1, {(CW-1){1'b0}}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] reload,
  output logic          expire,
  output logic [CW-1:0] count
);
  function automatic logic [CW-1:0] step(input logic [CW-1:0] cur,
                                         input logic [CW-1:0] rv,
                                         input logic go);
    logic [CW-1:0] n;
    if (!go || cur == CW'(1)) n = rv;
    else                       n = cur - CW'(1);
    return n;
  endfunction

  assign expire = run && (count == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= FULL;
    else        count <= step(count, reload, run);
  end

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) && (count <= FULL));

  assert_expire_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count == $past(reload));

  assert_idle_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == $past(reload)));

  assert_running_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !expire) |=> (count == $past(count) - CW'(1)));
endmodule

// File: rtl/spi_baud_sck.sv
module spi_baud_sck (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic toggle,
  output logic sck
);
  function automatic logic next_level(input logic cur, input logic en, input logic t);
    logic n;
    if (!en)    n = 1'b0;
    else if (t) n = ~cur;
    else        n = cur;
    return n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck <= 1'b0;
    else        sck <= next_level(sck, enable, toggle);
  end

  assert_sck_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sck);

  assert_sck_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !toggle) |=> $stable(sck));

  assert_sck_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && toggle) |=> (sck != $past(sck)));
endmodule

// File: rtl/spi_baud_timer.sv
module spi_baud_timer #(
  parameter int unsigned BYTE_W = spi_baud_pkg::BYTE_W,
  localparam int unsigned CW = 2 * BYTE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rate_hi,
  input  logic [BYTE_W-1:0] rate_lo,
  input  logic              ser_en,
  input  logic              tmr_irq_en,
  output logic              baud_tick,
  output logic              sck,
  output logic              tmr_irq
);
  logic          run_w;
  logic [CW-1:0] reload_w;
  logic [CW-1:0] count_w;
  logic          expire_w;

  assign run_w = ser_en | tmr_irq_en;

  spi_baud_reload #(.BYTE_W(BYTE_W)) u_reload (
    .hi_byte (rate_hi),
    .lo_byte (rate_lo),
    .reload  (reload_w)
  );

  spi_baud_counter #(.CW(CW)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_w),
    .reload (reload_w),
    .expire (expire_w),
    .count  (count_w)
  );

  spi_baud_sck u_sck (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (ser_en),
    .toggle (expire_w),
    .sck    (sck)
  );

  assign baud_tick = expire_w;
  assign tmr_irq   = expire_w & ~ser_en & tmr_irq_en;

  assert_irq_timer_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> !tmr_irq);

  assert_irq_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_en && tmr_irq_en) |-> (tmr_irq == baud_tick));

  assert_no_tick_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_en && !tmr_irq_en) |-> !baud_tick);

  assert_count_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count_w <= {1'b1, {(CW-1){1'b0}}});
endmodule

// File: tb/tb_spi_baud_timer.sv
module tb_spi_baud_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rate_hi = 8'd0;
  logic [7:0] rate_lo = 8'd0;
  logic       ser_en = 1'b0;
  logic       tmr_irq_en = 1'b0;
  logic       baud_tick, sck, tmr_irq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_baud_timer dut (
    .clk(clk), .rst_n(rst_n), .rate_hi(rate_hi), .rate_lo(rate_lo),
    .ser_en(ser_en), .tmr_irq_en(tmr_irq_en),
    .baud_tick(baud_tick), .sck(sck), .tmr_irq(tmr_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model: integer count, updated with pre-edge inputs.
  int m_cnt = 65536;
  bit m_sck = 1'b0;

  always @(posedge clk) begin
    int rv;
    bit act, tk;
    cycles++;
    if (!rst_n) begin
      m_cnt = 65536;
      m_sck = 1'b0;
    end else begin
      rv  = ({rate_hi, rate_lo} == 16'd0) ? 65536 : int'({rate_hi, rate_lo});
      act = ser_en | tmr_irq_en;
      tk  = act && (m_cnt == 1);
      if (!ser_en) m_sck = 1'b0;
      else if (tk) m_sck = ~m_sck;
      if (!act || tk) m_cnt = rv;
      else            m_cnt = m_cnt - 1;
    end
  end

  always @(negedge clk) begin
    bit e_tick, e_irq;
    if (!done) begin
      if (!rst_n) begin
        check(baud_tick == 1'b0 && sck == 1'b0 && tmr_irq == 1'b0, "R9 reset outputs",
              {baud_tick, sck, tmr_irq}, 0);
      end else begin
        e_tick = (ser_en | tmr_irq_en) && (m_cnt == 1);
        e_irq  = e_tick && !ser_en && tmr_irq_en;
        check(baud_tick == e_tick, "R1/R8 tick vs model", baud_tick, e_tick);
        check(sck == m_sck, "R4 sck vs model", sck, m_sck);
        check(tmr_irq == e_irq, "R5/R6 irq vs model", tmr_irq, e_irq);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles >= WATCHDOG && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic until_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!baud_tick && n < 70000);
  endtask

  initial begin
    int n;
    bit s0, s1;
    step(3);
    check(sck == 1'b0 && baud_tick == 1'b0, "R9 in reset", sck, 0);
    rst_n = 1'b1;
    step(1);
    @(negedge clk);
    check(sck == 1'b0 && tmr_irq == 1'b0, "R9 after release", tmr_irq, 0);

    // R8: idle, no tick, then first tick N cycles after enabling
    rate_lo = 8'd5;
    step(10);
    tmr_irq_en = 1'b1;
    until_tick(n);
    check(n == 5, "R8 first tick after enable", n, 5);
    check(tmr_irq == 1'b1, "R5 irq with tick", tmr_irq, 1);
    until_tick(n);
    check(n == 5, "R1 tick interval", n, 5);

    // R6/R4: serial mode with irq enable set
    step(1);
    tmr_irq_en = 1'b0; ser_en = 1'b1; rate_lo = 8'd3;
    until_tick(n);
    s0 = sck;
    until_tick(n);
    check(n == 3, "R4 half period", n, 3);
    s1 = sck;
    check(s0 != s1, "R4 sck alternates across ticks", s1, !s0);
    tmr_irq_en = 1'b1;
    until_tick(n);
    check(tmr_irq == 1'b0, "R6 irq masked in serial mode", tmr_irq, 0);
    step(1);
    ser_en = 1'b0; tmr_irq_en = 1'b0;
    step(1);
    @(negedge clk);
    check(sck == 1'b0, "R4 sck low when disabled", sck, 0);

    // R7: mid-count reload change
    rate_lo = 8'd10;
    step(2);
    tmr_irq_en = 1'b1;
    until_tick(n);
    step(1);
    step(3);
    rate_lo = 8'd4;
    until_tick(n);
    check(n == 7, "R7 current interval unchanged", n + 3, 10);
    until_tick(n);
    check(n == 4, "R7 new value at next reload", n, 4);

    // R1: reload of one ticks every cycle
    step(1);
    rate_lo = 8'd1;
    until_tick(n);
    until_tick(n);
    check(n == 1, "R1 reload one", n, 1);

    // R2: zero means 65536
    step(1);
    tmr_irq_en = 1'b0; rate_lo = 8'd0; rate_hi = 8'd0;
    step(2);
    tmr_irq_en = 1'b1;
    until_tick(n);
    check(n == 65536, "R2 zero reload span", n, 65536);

    // R1: high byte position
    step(1);
    tmr_irq_en = 1'b0; rate_hi = 8'd1; rate_lo = 8'd2;
    step(2);
    tmr_irq_en = 1'b1;
    until_tick(n);
    check(n == 258, "R1 high byte weight", n, 258);

    step(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule